// File: doc/BRIEF.md
# Cipher Extension Register File

This block is the private operand store of a block-cipher functional unit that sits beside a 32-bit RISC integer pipeline. It keeps ten 32-bit words: a two-word data block, a four-word cipher key and four key-schedule constants. Software loads the data block and the key one word at a time. The cipher datapath writes each result block back into the two data words in a single cycle. Between round pairs it issues a rotate command that moves the key words and the constant words round by one position, which lines up the next round keys.

All ten words are offered at once on a flat bus for the key-schedule and forwarding logic. A separate addressed port returns any one word for transfer back to the integer side. Reset clears the data and key words and preloads the constants, so software never has to write them. Any addressed write that collides with a paired write or a rotation is discarded, and the collision is reported on a one-cycle error flag.

Top module: `cxr_regfile`

## Requirements
- R1: While reset is high at a clock edge, words 0 to 5 become zero and words 6, 7, 8 and 9 become 0x01234567, 0x89ABCDEF, 0xFEDCBA98 and 0x76543210, and the error flag becomes low.
- R2: An addressed write to address 0 to 5, with no paired write and no rotation in the same cycle, stores the data in that word at the clock edge. Word n is seen on bits [32n+31:32n] of the flat view.
- R3: An addressed write to address 6 to 15 changes no word.
- R4: A paired write stores the high input in word 0 and the low input in word 1 at the clock edge.
- R5: When an addressed write and a paired write arrive in the same cycle, the paired write takes effect, the addressed write is discarded and the error flag is high in the following cycle.
- R6: A rotation moves word 3 to 2, 4 to 3, 5 to 4 and 2 to 5, and in the same edge word 7 to 6, 8 to 7, 9 to 8 and 6 to 9.
- R7: A paired write and a rotation in the same cycle both take effect.
- R8: An addressed write in the same cycle as a rotation is discarded, and the error flag is high in the following cycle.
- R9: The read port returns the word at the read address without a clock delay, and returns zero for addresses 10 to 15.
- R10: Four rotations with no other write return the key and constant words to their values before the first rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Addressed single-word write request |
| wr_addr | input | 4 | Word address for the addressed write |
| wr_data | input | 32 | Data for the addressed write |
| pair_en | input | 1 | Paired write of words 0 and 1 from the datapath |
| pair_hi | input | 32 | Upper half of the result block, to word 0 |
| pair_lo | input | 32 | Lower half of the result block, to word 1 |
| rot_en | input | 1 | Rotate key words and constant words by one |
| rd_addr | input | 4 | Address for the combinational read port |
| rd_data | output | 32 | Word selected by rd_addr |
| regs_flat | output | 320 | All ten words, word n at bits [32n+31:32n] |
| conflict_err | output | 1 | High for one cycle after a discarded addressed write |

## Verification
The stimulus first loads distinct words with plain addressed writes. It then writes to the constant and out-of-range addresses, which shows that protected words keep their reset values. Rotations are issued alone, together with a paired write and together with a colliding addressed write. Each probe reads a word whose expected value differs for a wrong rotation direction, a lost write and a wrong priority. The fourth rotation checks that the arrays wrap back to their starting contents. Every probe reads the same word through both the addressed port and the flat view, so a fault in the read mux is told apart from a fault in storage.

// File: rtl/cxr_pkg.sv
package cxr_pkg;
  localparam int unsigned CXR_W      = 32;
  localparam int unsigned CXR_AW     = 4;
  localparam int unsigned CXR_BANK   = 4;
  localparam int unsigned CXR_NREGS  = 2 + 2 * CXR_BANK;
  localparam int unsigned KEY_BASE   = 2;
  localparam int unsigned CONST_BASE = KEY_BASE + CXR_BANK;

  typedef logic [CXR_W-1:0] word_t;

  // Constant bank reset image, word 6 in the lowest slice.
  localparam logic [CXR_BANK*CXR_W-1:0] CONST_INIT =
    {32'h76543210, 32'hFEDCBA98, 32'h89ABCDEF, 32'h01234567};
endpackage

// File: rtl/cxr_wr_decode.sv
module cxr_wr_decode
  import cxr_pkg::*;
#(
  parameter int unsigned AW = CXR_AW
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          pair_en,
  input  logic          rot_en,
  output logic          data_we,
  output logic          key_we,
  output logic [1:0]    key_idx,
  output logic          collide
);
  logic blocked;
  logic in_data;
  logic in_key;

  always_comb begin
    blocked = pair_en || rot_en;
    in_data = (wr_addr < AW'(KEY_BASE));
    in_key  = (wr_addr >= AW'(KEY_BASE)) && (wr_addr < AW'(CONST_BASE));
    data_we = wr_en && in_data && !blocked;
    key_we  = wr_en && in_key && !blocked;
    // addresses 2..5 map to bank slots 0..3
    key_idx = wr_addr[1:0] - 2'd2;
    collide = wr_en && blocked;
  end

  // R5 R8: a blocked request never reaches a bank
  always_comb begin
    if (blocked) begin
      a_r8_no_write_when_blocked: assert (!data_we && !key_we);
    end
  end
endmodule

// File: rtl/cxr_data_pair.sv
module cxr_data_pair
  import cxr_pkg::*;
#(
  parameter int unsigned W = CXR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pair_en,
  input  logic [W-1:0] pair_hi,
  input  logic [W-1:0] pair_lo,
  input  logic         wr_en,
  input  logic         wr_idx,
  input  logic [W-1:0] wr_data,
  output logic [2*W-1:0] words
);
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (pair_en) begin
      hi_q <= pair_hi;
      lo_q <= pair_lo;
    end else if (wr_en) begin
      if (wr_idx) lo_q <= wr_data;
      else        hi_q <= wr_data;
    end
  end

  assign words = {lo_q, hi_q};

  a_r4_pair_store: assert property (@(posedge clk) disable iff (rst)
    pair_en |=> (hi_q == $past(pair_hi)) && (lo_q == $past(pair_lo)));
endmodule

// File: rtl/cxr_rot_bank.sv
module cxr_rot_bank
  import cxr_pkg::*;
#(
  parameter int unsigned W     = CXR_W,
  parameter int unsigned DEPTH = CXR_BANK,
  parameter logic [DEPTH*W-1:0] INIT = '0,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rot_en,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [W-1:0]   wr_data,
  output logic [DEPTH*W-1:0] words
);
  logic [W-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= INIT[i*W +: W];
    end else if (rot_en) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= slot[(i + 1) % DEPTH];
    end else if (wr_en) begin
      slot[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign words[g*W +: W] = slot[g];
  end

  a_r6_rotate_head: assert property (@(posedge clk) disable iff (rst)
    rot_en |=> slot[0] == $past(slot[1]));
  a_r6_rotate_wrap: assert property (@(posedge clk) disable iff (rst)
    rot_en |=> slot[DEPTH-1] == $past(slot[0]));
  a_r3_bank_hold: assert property (@(posedge clk) disable iff (rst)
    (!rot_en && !wr_en) |=> $stable(words));
endmodule

// File: rtl/cxr_regfile.sv
module cxr_regfile
  import cxr_pkg::*;
#(
  parameter int unsigned W  = CXR_W,
  parameter int unsigned AW = CXR_AW,
  localparam int unsigned NREGS = CXR_NREGS,
  localparam int unsigned BANK  = CXR_BANK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic             pair_en,
  input  logic [W-1:0]     pair_hi,
  input  logic [W-1:0]     pair_lo,
  input  logic             rot_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [W-1:0]     rd_data,
  output logic [NREGS*W-1:0] regs_flat,
  output logic             conflict_err
);
  logic       data_we;
  logic       key_we;
  logic [1:0] key_idx;
  logic       collide;
  logic [2*W-1:0]    data_words;
  logic [BANK*W-1:0] key_words;
  logic [BANK*W-1:0] const_words;

  cxr_wr_decode #(.AW(AW)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .pair_en(pair_en), .rot_en(rot_en),
    .data_we(data_we), .key_we(key_we), .key_idx(key_idx), .collide(collide)
  );

  cxr_data_pair #(.W(W)) u_data (
    .clk(clk), .rst(rst), .pair_en(pair_en), .pair_hi(pair_hi),
    .pair_lo(pair_lo), .wr_en(data_we), .wr_idx(wr_addr[0]),
    .wr_data(wr_data), .words(data_words)
  );

  cxr_rot_bank #(.W(W), .DEPTH(BANK), .INIT('0)) u_key (
    .clk(clk), .rst(rst), .rot_en(rot_en), .wr_en(key_we),
    .wr_idx(key_idx), .wr_data(wr_data), .words(key_words)
  );

  cxr_rot_bank #(.W(W), .DEPTH(BANK), .INIT(CONST_INIT)) u_const (
    .clk(clk), .rst(rst), .rot_en(rot_en), .wr_en(1'b0),
    .wr_idx('0), .wr_data('0), .words(const_words)
  );

  assign regs_flat = {const_words, key_words, data_words};

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_addr == AW'(i)) rd_data = regs_flat[i*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) conflict_err <= 1'b0;
    else     conflict_err <= collide;
  end

  a_r5_pair_conflict: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pair_en) |=> conflict_err);
  a_r8_rot_conflict: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rot_en) |=> conflict_err);
  a_r3_high_addr_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= AW'(CONST_BASE) && !pair_en && !rot_en)
      |=> $stable(regs_flat));
  a_r2_word_written: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < AW'(CONST_BASE) && !pair_en && !rot_en)
      |=> regs_flat[$past(wr_addr)*W +: W] == $past(wr_data));
endmodule

// File: tb/cxr_regfile_bench.sv
`timescale 1ns/1ps
module cxr_regfile_bench;
  localparam int W = 32;
  localparam int N = 10;

  typedef struct packed {
    logic        we;
    logic [3:0]  wa;
    logic [31:0] wd;
    logic        pe;
    logic [31:0] ph;
    logic [31:0] pl;
    logic        ro;
    logic [3:0]  ca;
    logic [31:0] ce;
    logic        ee;
  } vec_t;

  localparam int NV = 20;
  // we wa wd | pe ph pl | ro | probe addr, expected word, expected flag
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd0,  32'hA0A00001, 1'b0, 32'h0, 32'h0, 1'b0, 4'd0, 32'hA0A00001, 1'b0}, // R2
    '{1'b1, 4'd2,  32'h22220000, 1'b0, 32'h0, 32'h0, 1'b0, 4'd2, 32'h22220000, 1'b0}, // R2
    '{1'b1, 4'd3,  32'h33330000, 1'b0, 32'h0, 32'h0, 1'b0, 4'd3, 32'h33330000, 1'b0}, // R2
    '{1'b1, 4'd4,  32'h44440000, 1'b0, 32'h0, 32'h0, 1'b0, 4'd4, 32'h44440000, 1'b0}, // R2
    '{1'b1, 4'd5,  32'h55550000, 1'b0, 32'h0, 32'h0, 1'b0, 4'd5, 32'h55550000, 1'b0}, // R2
    '{1'b1, 4'd7,  32'hDEAD0007, 1'b0, 32'h0, 32'h0, 1'b0, 4'd7, 32'h89ABCDEF, 1'b0}, // R3
    '{1'b1, 4'd12, 32'hDEAD000C, 1'b0, 32'h0, 32'h0, 1'b0, 4'd5, 32'h55550000, 1'b0}, // R3
    '{1'b0, 4'd0,  32'h0, 1'b1, 32'h11112222, 32'h33334444, 1'b0, 4'd1, 32'h33334444, 1'b0}, // R4
    '{1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 32'h0, 1'b1, 4'd2, 32'h33330000, 1'b0}, // R6
    '{1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd5, 32'h22220000, 1'b0}, // R6
    '{1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd6, 32'h89ABCDEF, 1'b0}, // R6
    '{1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd9, 32'h01234567, 1'b0}, // R6
    '{1'b0, 4'd0,  32'h0, 1'b1, 32'hCAFE0000, 32'hBEEF0000, 1'b1, 4'd0, 32'hCAFE0000, 1'b0}, // R7
    '{1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd3, 32'h55550000, 1'b0}, // R7
    '{1'b1, 4'd1,  32'h0BAD0001, 1'b1, 32'h600D0000, 32'h600D0001, 1'b0, 4'd1, 32'h600D0001, 1'b1}, // R5
    '{1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd0, 32'h600D0000, 1'b0}, // R5
    '{1'b1, 4'd2,  32'h0BAD0002, 1'b0, 32'h0, 32'h0, 1'b1, 4'd2, 32'h55550000, 1'b1}, // R8
    '{1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 32'h0, 1'b1, 4'd2, 32'h22220000, 1'b0}, // R10
    '{1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd6, 32'h01234567, 1'b0}, // R10
    '{1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd4, 32'h44440000, 1'b0}  // R10
  };

  localparam logic [31:0] CONSTS [4] = '{32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic pair_en = 1'b0;
  logic [31:0] pair_hi = '0;
  logic [31:0] pair_lo = '0;
  logic rot_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [N*W-1:0] regs_flat;
  logic conflict_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cxr_regfile u_cxr_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pair_en(pair_en), .pair_hi(pair_hi), .pair_lo(pair_lo), .rot_en(rot_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_flat(regs_flat),
    .conflict_err(conflict_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #20000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset contents, seen through the read port and the flat view
    for (int a = 0; a < N; a++) begin
      rd_addr = 4'(a);
      #1;
      check("R1", rd_data, (a >= 6) ? CONSTS[a-6] : 32'h0);
      check("R1 flat", regs_flat[a*W +: W], (a >= 6) ? CONSTS[a-6] : 32'h0);
    end
    check("R1 flag", {31'b0, conflict_err}, 32'h0);
    // R9: addresses past the last word read zero
    for (int a = N; a < 16; a++) begin
      rd_addr = 4'(a);
      #1;
      check("R9 zero", rd_data, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VEC[i].we; wr_addr = VEC[i].wa; wr_data = VEC[i].wd;
      pair_en = VEC[i].pe; pair_hi = VEC[i].ph; pair_lo = VEC[i].pl;
      rot_en = VEC[i].ro; rd_addr = VEC[i].ca;
      @(negedge clk);
      wr_en = 1'b0; pair_en = 1'b0; rot_en = 1'b0;
      #1;
      check($sformatf("R9 vec%0d read", i), rd_data, VEC[i].ce);
      check($sformatf("R2 vec%0d flat", i), regs_flat[int'(VEC[i].ca)*W +: W], VEC[i].ce);
      check($sformatf("R5 R8 vec%0d flag", i), {31'b0, conflict_err}, {31'b0, VEC[i].ee});
    end

    // R1: reset in mid-run restores everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < N; a++) begin
      rd_addr = 4'(a);
      #1;
      check("R1 rerun", rd_data, (a >= 6) ? CONSTS[a-6] : 32'h0);
    end
    finish_run();
  end
endmodule